// File: doc/BRIEF.md
# Four-Column Carry Lookahead Unit

This block is the combinational carry lookahead stage of a fast adder. It takes a propagate/generate pair for each of four columns and a carry-in. From these it produces the three carries inside the group, the carry-out of the group, and a group-level propagate and generate pair.

Each carry is built as a flat two-level sum of products of the column pairs and the carry-in. No carry waits on another carry, so all carries come out after the same logic depth. A column propagate is the OR of its two operand bits, and a column generate is their AND.

The group pair does not depend on the carry-in. Because of this, the same unit can sit at a higher level of a lookahead tree, where it takes the group pairs of four lower units as its column inputs. The block has no clock and no state.

Top module: `cll_lookahead4`

## Requirements
- R1: `innerCarry[1]` equals `colGen[0] | (colProp[0] & carryIn)`.
- R2: For i = 2 and 3, `innerCarry[i]` equals the ripple recurrence `colGen[i-1] | (colProp[i-1] & c(i-1))`, where c0 is `carryIn`. The carry is still formed directly from the inputs.
- R3: `carryOut` equals the same recurrence applied to column 3. When all four columns propagate and none generates, `carryOut` follows `carryIn`.
- R4: `groupProp` is high exactly when all four bits of `colProp` are high.
- R5: `groupGen` equals `g3 | p3·g2 | p3·p2·g1 | p3·p2·p1·g0`. It has no carry-in term.
- R6: For any fixed `colProp` and `colGen`, `groupProp` and `groupGen` are the same for both values of `carryIn`.
- R7: `carryOut` always equals `groupGen | (groupProp & carryIn)`.
- R8: The unit can be reused one level up without change. The group pairs of four 4-bit slices of 16-bit operands (column p = a|b, g = a&b, lane 0 = least significant) are fed in as column inputs, with the adder carry-in as `carryIn`. The unit then returns the carries into bits 4, 8 and 12 on `innerCarry[1..3]`, and the carry out of bit 15 on `carryOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| colProp | input | LANES (4) | Per-column propagate, lane 0 least significant |
| colGen | input | LANES (4) | Per-column generate, lane 0 least significant |
| carryIn | input | 1 | Carry into column 0 |
| innerCarry | output | LANES-1 (3) | Carries into columns 1..3, index i = carry into column i |
| carryOut | output | 1 | Carry out of the top column |
| groupProp | output | 1 | Group propagate |
| groupGen | output | 1 | Group generate |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with zero register stages. The bench changes inputs just after a rising edge and compares all outputs at the following falling edge, half a period later. This leaves the values settled and keeps the comparison clear of the edge. In the two-level test, group pairs captured in earlier cycles are applied again as inputs, and the carries for that stimulus are checked at its own falling edge.

// File: rtl/cll_pkg.sv
package cll_pkg;
  localparam int unsigned CLL_LANES_DEFAULT = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } grp_pg_t;
endpackage

// File: rtl/cll_carry_net.sv
module cll_carry_net #(
  parameter int unsigned LANES = cll_pkg::CLL_LANES_DEFAULT
) (
  input  logic [LANES-1:0] colProp,
  input  logic [LANES-1:0] colGen,
  input  logic             carryIn,
  output logic [LANES:1]   carries
);
  // Flat sum of products for the carry out of column upTo:
  // one term per generating column j, ANDed with every propagate above it,
  // plus a term carrying carryIn through all columns 0..upTo.
  function automatic logic flatCarry(input logic [LANES-1:0] p,
                                     input logic [LANES-1:0] g,
                                     input logic c,
                                     input int upTo);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < int'(LANES); j++) begin
      if (j <= upTo) begin
        term = g[j];
        for (int k = 0; k < int'(LANES); k++) begin
          if (k > j && k <= upTo) term = term & p[k];
        end
        acc = acc | term;
      end
    end
    term = c;
    for (int k = 0; k < int'(LANES); k++) begin
      if (k <= upTo) term = term & p[k];
    end
    return acc | term;
  endfunction

  for (genvar i = 0; i < int'(LANES); i++) begin : g_col
    assign carries[i+1] = flatCarry(colProp, colGen, carryIn, i);
  end
endmodule

// File: rtl/cll_group_pg.sv
module cll_group_pg #(
  parameter int unsigned LANES = cll_pkg::CLL_LANES_DEFAULT
) (
  input  logic [LANES-1:0] colProp,
  input  logic [LANES-1:0] colGen,
  output cll_pkg::grp_pg_t groupPg
);
  logic [LANES-1:0] genTerms;

  // Term j: generate in column j passed through every column above it.
  for (genvar j = 0; j < int'(LANES); j++) begin : g_term
    if (j == int'(LANES) - 1) begin : g_top
      assign genTerms[j] = colGen[j];
    end else begin : g_low
      assign genTerms[j] = colGen[j] & (&colProp[LANES-1:j+1]);
    end
  end

  assign groupPg.prop = &colProp;
  assign groupPg.gen  = |genTerms;
endmodule

// File: rtl/cll_lookahead4.sv
module cll_lookahead4 #(
  parameter int unsigned LANES = cll_pkg::CLL_LANES_DEFAULT
) (
  input  logic [LANES-1:0] colProp,
  input  logic [LANES-1:0] colGen,
  input  logic             carryIn,
  output logic [LANES-1:1] innerCarry,
  output logic             carryOut,
  output logic             groupProp,
  output logic             groupGen
);
  logic [LANES:1]   allCarries;
  cll_pkg::grp_pg_t groupPg;

  cll_carry_net #(.LANES(LANES)) u_carry (
    .colProp (colProp),
    .colGen  (colGen),
    .carryIn (carryIn),
    .carries (allCarries)
  );

  cll_group_pg #(.LANES(LANES)) u_group (
    .colProp (colProp),
    .colGen  (colGen),
    .groupPg (groupPg)
  );

  assign innerCarry = allCarries[LANES-1:1];
  assign carryOut   = allCarries[LANES];
  assign groupProp  = groupPg.prop;
  assign groupGen   = groupPg.gen;
endmodule

// File: rtl/cll_lookahead4_chk.sv
module cll_lookahead4_chk #(
  parameter int unsigned LANES = cll_pkg::CLL_LANES_DEFAULT
) (
  input logic [LANES-1:0] colProp,
  input logic [LANES-1:0] colGen,
  input logic             carryIn,
  input logic [LANES-1:1] innerCarry,
  input logic             carryOut,
  input logic             groupProp,
  input logic             groupGen
);
  // Carries come from the flat network and the group pair from a separate
  // module; these checks tie them together through the ripple recurrence.
  always_comb begin
    p_first_carry_r1: assert (innerCarry[1] == (colGen[0] | (colProp[0] & carryIn)));
    for (int i = 2; i < int'(LANES); i++) begin
      p_ripple_step_r2: assert (innerCarry[i] ==
                                (colGen[i-1] | (colProp[i-1] & innerCarry[i-1])));
    end
    p_carry_out_r3: assert (carryOut ==
                            (colGen[LANES-1] | (colProp[LANES-1] & innerCarry[LANES-1])));
    if (groupProp && colGen == '0) begin
      p_prop_passthru_r4: assert (carryOut == carryIn);
    end
    if (groupGen) begin
      p_gen_forces_r5: assert (carryOut);
    end
    p_group_combine_r7: assert (carryOut == (groupGen | (groupProp & carryIn)));
  end
endmodule

bind cll_lookahead4 cll_lookahead4_chk #(.LANES(LANES)) u_chk (
  .colProp    (colProp),
  .colGen     (colGen),
  .carryIn    (carryIn),
  .innerCarry (innerCarry),
  .carryOut   (carryOut),
  .groupProp  (groupProp),
  .groupGen   (groupGen)
);

// File: tb/tb_cll_lookahead4.sv
module tb_cll_lookahead4;
  logic       clk = 1'b0;
  logic [3:0] colProp = '0;
  logic [3:0] colGen = '0;
  logic       carryIn = 1'b0;
  logic [3:1] innerCarry;
  logic       carryOut;
  logic       groupProp;
  logic       groupGen;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cll_lookahead4 #(.LANES(4)) dut (
    .colProp    (colProp),
    .colGen     (colGen),
    .carryIn    (carryIn),
    .innerCarry (innerCarry),
    .carryOut   (carryOut),
    .groupProp  (groupProp),
    .groupGen   (groupGen)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (p=%b g=%b c0=%b)",
               req, actual, expected, colProp, colGen, carryIn);
    end
  endtask

  task automatic apply(input logic [3:0] p, input logic [3:0] g, input logic c);
    @(posedge clk);
    colProp = p;
    colGen  = g;
    carryIn = c;
    @(negedge clk);
  endtask

  bit savedP [256];
  bit savedG [256];

  task automatic twoLevel(input logic [15:0] a, input logic [15:0] b, input logic cin);
    logic [3:0] gp;
    logic [3:0] gg;
    int expC;
    for (int n = 0; n < 4; n++) begin
      apply(a[4*n +: 4] | b[4*n +: 4], a[4*n +: 4] & b[4*n +: 4], 1'b0);
      gp[n] = groupProp;
      gg[n] = groupGen;
    end
    apply(gp, gg, cin);
    for (int k = 1; k <= 4; k++) begin
      int width = 4 * k;
      longint lo = (longint'(a) & ((64'd1 << width) - 1)) +
                   (longint'(b) & ((64'd1 << width) - 1)) + longint'(cin);
      expC = int'((lo >> width) & 1);
      if (k < 4) check(innerCarry[k] == expC[0], "R8 upper-level carry", int'(innerCarry[k]), expC);
      else       check(carryOut == expC[0], "R8 upper-level carry-out", int'(carryOut), expC);
    end
  endtask

  initial begin
    // Inputs start at zero: all outputs must be low.
    @(negedge clk);
    check(innerCarry == 3'b000 && !carryOut && !groupProp && !groupGen,
          "R1 idle state", int'({innerCarry, carryOut, groupProp, groupGen}), 0);

    for (int v = 0; v < 512; v++) begin
      logic [3:0] p = v[3:0];
      logic [3:0] g = v[7:4];
      logic c = v[8];
      logic [4:0] rc;
      logic refG;
      apply(p, g, c);
      rc[0] = c;
      for (int i = 0; i < 4; i++) rc[i+1] = g[i] | (p[i] & rc[i]);
      refG = 1'b0;
      for (int j = 0; j < 4; j++) begin
        logic t = g[j];
        for (int k = j + 1; k < 4; k++) t = t & p[k];
        refG = refG | t;
      end
      check(innerCarry[1] == rc[1], "R1 c1", int'(innerCarry[1]), int'(rc[1]));
      check(innerCarry[2] == rc[2], "R2 c2", int'(innerCarry[2]), int'(rc[2]));
      check(innerCarry[3] == rc[3], "R2 c3", int'(innerCarry[3]), int'(rc[3]));
      check(carryOut == rc[4], "R3 c4", int'(carryOut), int'(rc[4]));
      check(groupProp == (p == 4'hF), "R4 group propagate", int'(groupProp), int'(p == 4'hF));
      check(groupGen == refG, "R5 group generate", int'(groupGen), int'(refG));
      check(carryOut == (refG | ((p == 4'hF) & c)), "R7 carry-out from group pair",
            int'(carryOut), int'(refG | ((p == 4'hF) & c)));
      if (!c) begin
        savedP[v[7:0]] = groupProp;
        savedG[v[7:0]] = groupGen;
      end else begin
        check(groupProp == savedP[v[7:0]] && groupGen == savedG[v[7:0]],
              "R6 group pair independent of carry-in",
              int'({groupProp, groupGen}), int'({savedP[v[7:0]], savedG[v[7:0]]}));
      end
    end

    // R3 corner: full propagate chain, no generate, carry-in passes straight through.
    apply(4'hF, 4'h0, 1'b1);
    check(carryOut == 1'b1, "R3 full propagate chain", int'(carryOut), 1);
    apply(4'hF, 4'h0, 1'b0);
    check(carryOut == 1'b0, "R3 full propagate chain", int'(carryOut), 0);

    // R8: reuse as parent of four 4-bit groups.
    twoLevel(16'hFFFF, 16'h0000, 1'b1);
    twoLevel(16'hFFFF, 16'h0000, 1'b0);
    twoLevel(16'h0F0F, 16'h00F1, 1'b0);
    twoLevel(16'h8000, 16'h8000, 1'b0);
    twoLevel(16'h1234, 16'hEDCB, 1'b1);
    twoLevel(16'hA5A5, 16'h5A5B, 1'b0);
    twoLevel(16'h0FFF, 16'h0001, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule